// File: doc/BRIEF.md
# Serial Peripheral Receive/Transmit DMA Pair

This block moves characters between one serial peripheral and memory, so the processor does not have to. It has two channels. The receive channel takes each character that the peripheral has ready and writes it to memory. The transmit channel reads the next character from memory each time the peripheral's transmitter is free. Each channel holds a memory pointer and a 16-bit transfer counter. Software programs both through a small register window that belongs to the peripheral.

Memory is reached through a single-beat request/grant port, and only one access is outstanding at a time. When a memory access completes, the pointer steps by the character size and the counter steps down by one. When a counter reaches zero, that channel stops and raises a level end-of-transfer flag. The flag stays set until software writes a new nonzero count to that channel.

Top module: `serial_dma_pair`

## Requirements
- R1: After reset, both pointers and both counts read as zero, both end-of-transfer flags and `eot_irq` are low, and `mem_req` is low.
- R2: Register offsets on `reg_addr`: 0 receive pointer, 1 receive count, 2 transmit pointer, 3 transmit count, 4 status. Status is read-only, with bit 0 the receive flag and bit 1 the transmit flag. Counts occupy bits 15:0. `reg_rdata` shows the addressed register in the same cycle, and a write takes effect at the next clock edge.
- R3: When the block is idle, `rx_ready` is high and the receive count is nonzero, `rx_take` is high in that cycle. From the next cycle, `mem_req` and `mem_we` are high, `mem_addr` equals the receive pointer and `mem_wdata` equals the captured `rx_char`.
- R4: When the block is idle, `tx_free` is high and the transmit count is nonzero, a read starts with `mem_req` high and `mem_we` low at the transmit pointer. In the grant cycle, `tx_load` is high and `tx_char` equals `mem_rdata`.
- R5: When an access is granted, the channel's pointer grows by UNIT_BYTES and its count drops by one. Both changes are visible in the next cycle.
- R6: A channel whose count is zero ignores its peripheral request. `rx_take` stays low and no memory request is made.
- R7: When both channels are eligible in the same idle cycle, the receive channel is served first, and the transmit channel follows once the receive access has completed.
- R8: When a granted access takes a count from 1 to 0, that channel's flag sets in the next cycle and `eot_irq` rises. The flag holds until a nonzero count is written to that channel. Writing a zero count leaves it set.
- R9: While an access is outstanding, `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_grant`, and no new peripheral request is taken.
- R10: A software write to a pointer or count in the same cycle as that channel's grant wins over the hardware update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| rx_ready | input | 1 | Peripheral has a received character |
| rx_char | input | CHAR_W | Received character |
| rx_take | output | 1 | Character accepted |
| tx_free | input | 1 | Peripheral transmitter is free |
| tx_load | output | 1 | `tx_char` is valid for the transmitter |
| tx_char | output | CHAR_W | Character for the transmitter |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 means write, 0 means read |
| mem_size | output | 1 | 0 means byte, 1 means halfword |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | CHAR_W | Write data |
| mem_grant | input | 1 | Access completes this cycle |
| mem_rdata | input | CHAR_W | Read data, valid with grant |
| rx_eot | output | 1 | Receive end-of-transfer flag |
| tx_eot | output | 1 | Transmit end-of-transfer flag |
| eot_irq | output | 1 | Either flag set |

## Verification
A corrupted pointer appears on `mem_addr` at the very next access of that channel. The same error shows in a register read one cycle after the grant. A wrong count reveals itself in two ways: either the end-of-transfer flag rises one access early or late, or the channel keeps accepting characters after it should have stopped. A broken arbitration or busy state shows up within a cycle as a second `rx_take` while `mem_req` is high, or as a write cycle where a read was expected.

// File: rtl/serial_dma_pair.sv
module serial_dma_pair #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int UNIT_BYTES = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [2:0]              reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  input  logic                    rx_ready,
  input  logic [8*UNIT_BYTES-1:0] rx_char,
  output logic                    rx_take,
  input  logic                    tx_free,
  output logic                    tx_load,
  output logic [8*UNIT_BYTES-1:0] tx_char,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic                    mem_size,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [8*UNIT_BYTES-1:0] mem_wdata,
  input  logic                    mem_grant,
  input  logic [8*UNIT_BYTES-1:0] mem_rdata,
  output logic                    rx_eot,
  output logic                    tx_eot,
  output logic                    eot_irq
);
  localparam int CHAR_W = 8 * UNIT_BYTES;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(UNIT_BYTES);

  logic [ADDR_W-1:0] ptr  [2];
  logic [CNT_W-1:0]  cnt  [2];
  logic [1:0]        eot;
  logic              busy, cur;
  logic [ADDR_W-1:0] abuf;
  logic [CHAR_W-1:0] wbuf;

  wire rx_go = !busy && rx_ready && (cnt[0] != '0);
  wire tx_go = !busy && tx_free && (cnt[1] != '0) && !rx_go;
  wire done  = busy && mem_grant;

  assign rx_take   = rx_go;
  assign mem_req   = busy;
  assign mem_we    = busy && !cur;
  assign mem_addr  = abuf;
  assign mem_wdata = wbuf;
  assign mem_size  = (UNIT_BYTES == 2);
  assign tx_load   = done && cur;
  assign tx_char   = mem_rdata;
  assign rx_eot    = eot[0];
  assign tx_eot    = eot[1];
  assign eot_irq   = |eot;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = 32'(ptr[0]);
      3'd1:    reg_rdata = 32'(cnt[0]);
      3'd2:    reg_rdata = 32'(ptr[1]);
      3'd3:    reg_rdata = 32'(cnt[1]);
      3'd4:    reg_rdata = {30'd0, eot};
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cur  <= 1'b0;
      abuf <= '0;
      wbuf <= '0;
      eot  <= 2'b00;
      for (int i = 0; i < 2; i++) begin
        ptr[i] <= '0;
        cnt[i] <= '0;
      end
    end else begin
      if (rx_go || tx_go) begin
        busy <= 1'b1;
        cur  <= tx_go;
        abuf <= tx_go ? ptr[1] : ptr[0];
        wbuf <= rx_char;
      end else if (done) begin
        busy <= 1'b0;
      end
      for (int i = 0; i < 2; i++) begin
        if (done && (cur == i[0]) && (cnt[i] != '0)) begin
          ptr[i] <= ptr[i] + STEP;
          cnt[i] <= cnt[i] - 1'b1;
          if (cnt[i] == CNT_W'(1)) eot[i] <= 1'b1;
        end
        if (reg_wr && reg_addr == 3'(2*i))
          ptr[i] <= reg_wdata[ADDR_W-1:0];
        if (reg_wr && reg_addr == 3'(2*i+1)) begin
          cnt[i] <= reg_wdata[CNT_W-1:0];
          if (reg_wdata[CNT_W-1:0] != '0) eot[i] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/serial_dma_pair_chk.sv
module serial_dma_pair_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [2:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              rx_take,
  input logic              tx_load,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_grant,
  input logic              rx_eot
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !mem_req);
  // R3
  rx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_take |=> mem_req && mem_we);
  // R4
  tx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> mem_grant && !mem_we);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_grant |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !rx_take);
  // R8
  eot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_eot && !(reg_wr && reg_addr == 3'd1 && reg_wdata[CNT_W-1:0] != '0) |=> rx_eot);
  // R8
  eot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 3'd1 && reg_wdata[CNT_W-1:0] != '0 |=> !rx_eot);
endmodule

bind serial_dma_pair serial_dma_pair_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .rx_take(rx_take), .tx_load(tx_load),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_grant(mem_grant), .rx_eot(rx_eot)
);

// File: tb/sim_serial_dma_pair.sv
`timescale 1ns/1ps
module sim_serial_dma_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        rx_ready = 1'b0;
  logic [7:0]  rx_char = 8'd0;
  logic        rx_take;
  logic        tx_free = 1'b0;
  logic        tx_load;
  logic [7:0]  tx_char;
  logic        mem_req, mem_we, mem_size;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_grant = 1'b0;
  logic [7:0]  mem_rdata;
  logic        rx_eot, tx_eot, eot_irq;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [31:0] ptr_m [2];
  logic [15:0] cnt_m [2];
  bit          eot_m [2];

  always #2.5 clk = ~clk;

  serial_dma_pair u0 (.*);

  function automatic logic [7:0] mem_model(input logic [31:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction
  assign mem_rdata = mem_model(mem_addr);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 3'd0) ptr_m[0] = d;
    if (a == 3'd2) ptr_m[1] = d;
    if (a == 3'd1) begin cnt_m[0] = d[15:0]; if (d[15:0] != 0) eot_m[0] = 0; end
    if (a == 3'd3) begin cnt_m[1] = d[15:0]; if (d[15:0] != 0) eot_m[1] = 0; end
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req);
    reg_addr = a;
    #0.5;
    chk(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  task automatic check_state(input string req);
    rd(3'd0, ptr_m[0], req);
    rd(3'd1, 32'(cnt_m[0]), req);
    rd(3'd2, ptr_m[1], req);
    rd(3'd3, 32'(cnt_m[1]), req);
    rd(3'd4, {30'd0, eot_m[1], eot_m[0]}, req);
    chk(eot_irq == (eot_m[0] | eot_m[1]), req, eot_irq, eot_m[0] | eot_m[1]);
  endtask

  // serve one memory access of channel ch; optional software write in the grant cycle
  task automatic serve(input int ch, input logic [7:0] wd, input int dly,
                       input bit swr, input logic [2:0] sa, input logic [31:0] sd);
    int guard = 0;
    logic [31:0] a;
    @(negedge clk); #0.5;
    while (!mem_req && guard < 6) begin @(negedge clk); #0.5; guard++; end
    chk(mem_req, "R3/R4 request", mem_req, 1);
    if (ch == 0) rx_ready = 1'b0; else tx_free = 1'b0;
    a = ptr_m[ch];
    chk(mem_we == (ch == 0), ch == 0 ? "R3 we" : "R4 we", mem_we, ch == 0);
    chk(mem_addr == a, ch == 0 ? "R3 addr" : "R4 addr", mem_addr, a);
    if (ch == 0) chk(mem_wdata == wd, "R3 data", mem_wdata, wd);
    for (int k = 0; k < dly; k++) begin
      @(negedge clk); #0.5;
      chk(mem_req && mem_addr == a, "R9 hold", mem_addr, a);
      chk(!rx_take, "R9 no take while busy", rx_take, 0);
    end
    @(negedge clk);
    mem_grant = 1'b1;
    if (swr) begin reg_wr = 1'b1; reg_addr = sa; reg_wdata = sd; end
    #0.5;
    if (ch == 1) begin
      chk(tx_load, "R4 load", tx_load, 1);
      chk(tx_char == mem_model(a), "R4 char", tx_char, mem_model(a));
    end else chk(!tx_load, "R4 no load on write", tx_load, 0);
    @(negedge clk);
    mem_grant = 1'b0; reg_wr = 1'b0;
    if (cnt_m[ch] != 0) begin
      ptr_m[ch] = ptr_m[ch] + 1;
      cnt_m[ch] = cnt_m[ch] - 1;
      if (cnt_m[ch] == 0) eot_m[ch] = 1;
    end
    if (swr) begin
      if (sa == 3'(2*ch)) ptr_m[ch] = sd;
      if (sa == 3'(2*ch+1)) begin cnt_m[ch] = sd[15:0]; if (sd[15:0] != 0) eot_m[ch] = 0; end
    end
    #0.5;
  endtask

  task automatic do_rx(input logic [7:0] c, input int dly);
    @(negedge clk);
    rx_ready = 1'b1; rx_char = c;
    #0.5;
    chk(rx_take, "R3 take", rx_take, 1);
    serve(0, c, dly, 0, 3'd0, 0);
  endtask

  task automatic do_tx(input int dly);
    @(negedge clk);
    tx_free = 1'b1;
    serve(1, 0, dly, 0, 3'd0, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 2; i++) begin ptr_m[i] = 0; cnt_m[i] = 0; eot_m[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    check_state("R1 reset");
    chk(!mem_req, "R1 req", mem_req, 0);

    // R6: idle channel ignores requests
    @(negedge clk);
    rx_ready = 1'b1; tx_free = 1'b1; rx_char = 8'h33;
    for (int k = 0; k < 3; k++) begin
      #0.5;
      chk(!rx_take, "R6 take", rx_take, 0);
      chk(!mem_req, "R6 req", mem_req, 0);
      @(negedge clk);
    end
    rx_ready = 1'b0; tx_free = 1'b0;

    // R2 register map
    wr(3'd0, 32'h1000_0010);
    wr(3'd1, 32'h0000_0002);
    wr(3'd2, 32'h2000_0080);
    wr(3'd3, 32'h0000_0003);
    check_state("R2 map");
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, 32'd0, "R2 status read-only");

    // R3, R5
    do_rx(8'h5C, 0);
    check_state("R5 rx step");
    // R8: last rx unit sets flag
    do_rx(8'hC3, 2);
    check_state("R8 rx flag");
    chk(rx_eot && eot_irq, "R8 irq", eot_irq, 1);
    // R6 after completion
    @(negedge clk); rx_ready = 1'b1; #0.5;
    chk(!rx_take, "R6 exhausted", rx_take, 0);
    @(negedge clk); rx_ready = 1'b0; #0.5;
    chk(!mem_req, "R6 exhausted req", mem_req, 0);
    wr(3'd1, 32'd0);
    check_state("R8 zero write keeps flag");
    wr(3'd1, 32'd2);
    check_state("R8 nonzero write clears");

    // R4
    do_tx(1);
    check_state("R4/R5 tx step");

    // R7: both at once, receive first
    @(negedge clk);
    rx_ready = 1'b1; tx_free = 1'b1; rx_char = 8'h7E;
    #0.5;
    chk(rx_take, "R7 rx first", rx_take, 1);
    serve(0, 8'h7E, 1, 0, 3'd0, 0);
    serve(1, 0, 0, 0, 3'd0, 0);
    check_state("R7 order");

    // R10: software write wins in grant cycle
    @(negedge clk);
    rx_ready = 1'b1; rx_char = 8'h11;
    serve(0, 8'h11, 1, 1, 3'd0, 32'h0000_4000);
    check_state("R10 ptr write wins");
    @(negedge clk);
    tx_free = 1'b1;
    serve(1, 0, 0, 1, 3'd3, 32'd5);
    check_state("R10 cnt write wins");

    // random mix
    for (int it = 0; it < 300; it++) begin
      int op = int'($urandom % 3);
      for (int ch = 0; ch < 2; ch++)
        if (cnt_m[ch] == 0) begin
          wr(3'(2*ch), $urandom);
          wr(3'(2*ch+1), 32'(1 + $urandom % 4));
        end
      if (op == 0) do_rx(8'($urandom), int'($urandom % 4));
      else if (op == 1) do_tx(int'($urandom % 4));
      else begin
        logic [7:0] c = 8'($urandom);
        @(negedge clk);
        rx_ready = 1'b1; tx_free = 1'b1; rx_char = c;
        #0.5;
        chk(rx_take, "R7 random rx first", rx_take, 1);
        serve(0, c, int'($urandom % 3), 0, 3'd0, 0);
        serve(1, 0, int'($urandom % 3), 0, 3'd0, 0);
      end
      check_state("R5/R8 random");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule